// File: doc/BRIEF.md
# Inbound Mailbox Register Window

This block is the host side of an inbound mailbox. A coprocessor drops 32-bit words into a small in-order queue through a push port. The host reaches the queue through a 32-bit register window. A read at the pop offsets removes and returns the oldest word. A read at the peek offset shows that word and leaves it in place. The window also has a packed occupancy status word and a configuration word. The configuration word holds a data-interrupt enable and a data-pending flag. The block drives a level interrupt for as long as words are waiting and the enable is set. It also passes through, on a fixed offset, a status word that a second, outbound queue supplies.

Queue occupancy is tracked by a three-state machine. `Q_EMPTY` means no words are held. `Q_HOLDING` means between one and DEPTH-1 words are held. `Q_FULL` means DEPTH words are held. The transitions are:
- `fill_first`: `Q_EMPTY` to `Q_HOLDING`, on a push.
- `fill_last`: `Q_HOLDING` to `Q_FULL`, when the count reaches DEPTH.
- `drain_last`: `Q_HOLDING` to `Q_EMPTY`, when the count reaches zero.
- `drain_one`: `Q_FULL` to `Q_HOLDING`, on a pop.
- `fill_direct`: `Q_EMPTY` to `Q_FULL`, taken only when DEPTH is 1.
- `drain_direct`: `Q_FULL` to `Q_EMPTY`, taken only when DEPTH is 1.

Slots that no word occupies hold the marker 32'hFFFF_FFFF.

Top module: `mbox_regs`

## Requirements
- R1: Only bus_addr[7:0] is decoded, and the address bits above bit 7 have no effect. Every offset from 0x80 through 0x8F is a pop offset.
- R2: A read at a pop offset returns the oldest held word and removes it. Words come out in the order they were pushed.
- R3: A read at a pop offset while the queue is empty returns 32'hFFFF_FFFF and leaves the count at zero.
- R4: A read at offset 0x90 returns the oldest word without removing it. When the queue is empty it returns 32'hFFFF_FFFF.
- R5: A read at offset 0x98 returns the status word. Bit 31 is 1 when the count equals DEPTH. Bit 30 is 1 when the count is zero. Bits 7:0 hold the count. All other bits are zero.
- R6: A read at offset 0x9C returns the config word. Bit 0 is the interrupt enable and is the only bit a write changes; it takes bus_wr_data[0]. Bit 4 reads 1 whenever the queue is not empty. All other bits read zero.
- R7: irq is registered. It equals (enable AND count nonzero) for the state present after each clock edge, so it changes on the edge that follows the push, the pop or the config write.
- R8: A push is accepted only when the count before the edge is below DEPTH. A push against a full queue is dropped, even when a pop happens in the same cycle. A push and a pop in the same cycle both take effect otherwise.
- R9: After a pop, the vacated slot holds 32'hFFFF_FFFF. Once the queue has been drained, a peek returns the marker again.
- R10: A read at offset 0xB8 returns outb_status as sampled at the read edge. Reads at any other unlisted offset return zero. Writes to any offset other than 0x9C change nothing.
- R11: bus_rd_data is loaded on the clock edge at which bus_rd_en is sampled high, and it reflects the state before that edge.
- R12: After reset the count is zero, the config word is zero, irq is 0 and every slot holds the marker.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Register byte address; only the low 8 bits are decoded |
| bus_wr_en | input | 1 | Register write strobe |
| bus_wr_data | input | 32 | Register write data |
| bus_rd_en | input | 1 | Register read strobe |
| bus_rd_data | output | 32 | Registered read data |
| push_valid | input | 1 | Coprocessor push strobe |
| push_data | input | 32 | Word to enqueue |
| outb_status | input | 32 | Status word of the outbound queue |
| irq | output | 1 | Level interrupt: data waiting and enabled |

## Verification
The queue is driven by pushes alone, then by pops alone, and then by pushes and pops in the same cycle. Comparing these separates the write-index arithmetic from the shifting of slots. Pushing against a full queue, with and without a pop in the same cycle, shows whether acceptance is decided on the count before the edge. Popping and peeking an empty queue, and peeking after a full drain, shows whether the marker is refilled. A random mix of pushes, reads, config writes and aliased upper address bits is then checked against a behavioural queue model on every clock.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
    localparam logic [31:0] MBOX_MARK      = 32'hFFFF_FFFF;
    localparam logic [3:0]  OFS_POP_NIB    = 4'h8;
    localparam logic [7:0]  OFS_PEEK       = 8'h90;
    localparam logic [7:0]  OFS_STATUS     = 8'h98;
    localparam logic [7:0]  OFS_CONFIG     = 8'h9C;
    localparam logic [7:0]  OFS_OUT_STATUS = 8'hB8;

    typedef enum logic [1:0] {
        Q_EMPTY   = 2'd0,
        Q_HOLDING = 2'd1,
        Q_FULL    = 2'd2
    } occ_state_t;
endpackage

// File: rtl/mbox_occupancy.sv
module mbox_occupancy
    import mbox_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pop_req,
    input  logic             push_req,
    output logic             pop_go,
    output logic             push_go,
    output logic [CNT_W-1:0] count,
    output logic [CNT_W-1:0] count_nx,
    output occ_state_t       state
);
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(DEPTH);

    occ_state_t state_nx;

    // Transition conditions
    always_comb begin
        pop_go   = pop_req && (state != Q_EMPTY);
        push_go  = push_req && (state != Q_FULL);
        count_nx = count + CNT_W'(push_go) - CNT_W'(pop_go);
        state_nx = state;
        unique case (state)
            Q_EMPTY: begin
                if (push_go)
                    state_nx = (count_nx == CNT_MAX) ? Q_FULL : Q_HOLDING; // fill_direct / fill_first
            end
            Q_HOLDING: begin
                if (count_nx == '0)
                    state_nx = Q_EMPTY;                                    // drain_last
                else if (count_nx == CNT_MAX)
                    state_nx = Q_FULL;                                     // fill_last
            end
            Q_FULL: begin
                if (pop_go)
                    state_nx = (count_nx == '0) ? Q_EMPTY : Q_HOLDING;     // drain_direct / drain_one
            end
            default: state_nx = Q_EMPTY;
        endcase
    end

    // State and count registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= Q_EMPTY;
            count <= '0;
        end else begin
            state <= state_nx;
            count <= count_nx;
        end
    end

    assert_count_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CNT_MAX);
    assert_state_tracks_count_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == Q_EMPTY) == (count == '0)) && ((state == Q_FULL) == (count == CNT_MAX)));
    assert_empty_pop_keeps_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_req && !push_req && count == '0) |=> count == '0);
    assert_full_push_dropped_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (push_req && !pop_req && count == CNT_MAX) |=> count == CNT_MAX);
endmodule

// File: rtl/mbox_slots.sv
module mbox_slots
    import mbox_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pop_go,
    input  logic             push_go,
    input  logic [31:0]      push_data,
    input  logic [CNT_W-1:0] count,
    output logic [31:0]      head
);
    logic [31:0]      slot [DEPTH];
    logic [CNT_W-1:0] wr_idx;

    assign wr_idx = count - CNT_W'(pop_go);
    assign head   = slot[0];

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        logic [31:0] shifted;
        if (i == DEPTH - 1) begin : g_tail
            assign shifted = MBOX_MARK;
        end else begin : g_body
            assign shifted = slot[i+1];
        end

        always_ff @(posedge clk) begin
            if (!rst_n)
                slot[i] <= MBOX_MARK;
            else if (push_go && wr_idx == CNT_W'(i))
                slot[i] <= push_data;
            else if (pop_go)
                slot[i] <= shifted;
        end
    end

    assert_tail_refill_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_go && !push_go) |=> slot[DEPTH-1] == MBOX_MARK);
    assert_head_after_pop_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_go && count > CNT_W'(1)) |=> head == $past(slot[1]));
endmodule

// File: rtl/mbox_regs.sv
module mbox_regs
    import mbox_pkg::*;
#(
    parameter int DEPTH  = 8,
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr_en,
    input  logic [31:0]       bus_wr_data,
    input  logic              bus_rd_en,
    output logic [31:0]       bus_rd_data,
    input  logic              push_valid,
    input  logic [31:0]       push_data,
    input  logic [31:0]       outb_status,
    output logic              irq
);
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [7:0]       ofs;
    logic             sel_pop;
    logic             pop_go;
    logic             push_go;
    logic [CNT_W-1:0] count;
    logic [CNT_W-1:0] count_nx;
    occ_state_t       state;
    logic [31:0]      head;
    logic             cfg_en;
    logic             cfg_en_nx;
    logic [31:0]      rd_mux;
    logic             unused_bits;

    assign ofs         = bus_addr[7:0];
    assign sel_pop     = (ofs[7:4] == OFS_POP_NIB);
    assign unused_bits = ^{bus_addr[ADDR_W-1:8], bus_wr_data[31:1]};

    mbox_occupancy #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_occ (
        .clk      (clk),
        .rst_n    (rst_n),
        .pop_req  (bus_rd_en && sel_pop),
        .push_req (push_valid),
        .pop_go   (pop_go),
        .push_go  (push_go),
        .count    (count),
        .count_nx (count_nx),
        .state    (state)
    );

    mbox_slots #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_slots (
        .clk       (clk),
        .rst_n     (rst_n),
        .pop_go    (pop_go),
        .push_go   (push_go),
        .push_data (push_data),
        .count     (count),
        .head      (head)
    );

    assign cfg_en_nx = (bus_wr_en && ofs == OFS_CONFIG) ? bus_wr_data[0] : cfg_en;

    always_comb begin
        rd_mux = '0;
        if (sel_pop) begin
            rd_mux = (state == Q_EMPTY) ? MBOX_MARK : head;
        end else begin
            unique case (ofs)
                OFS_PEEK:       rd_mux = head;
                OFS_STATUS:     rd_mux = {state == Q_FULL, state == Q_EMPTY, 22'd0, 8'(count)};
                OFS_CONFIG:     rd_mux = {27'd0, state != Q_EMPTY, 3'd0, cfg_en};
                OFS_OUT_STATUS: rd_mux = outb_status;
                default:        rd_mux = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_en      <= 1'b0;
            irq         <= 1'b0;
            bus_rd_data <= '0;
        end else begin
            cfg_en <= cfg_en_nx;
            irq    <= cfg_en_nx && (count_nx != '0);
            if (bus_rd_en)
                bus_rd_data <= rd_mux;
        end
    end

    assert_irq_level_R7: assert property (@(posedge clk) disable iff (!rst_n)
        irq == (cfg_en && state != Q_EMPTY));
    assert_out_status_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd_en && ofs == OFS_OUT_STATUS) |=> bus_rd_data == $past(outb_status));
    assert_empty_pop_marker_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd_en && sel_pop && state == Q_EMPTY) |=> bus_rd_data == MBOX_MARK);
    assert_rd_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd_en |=> $stable(bus_rd_data));
endmodule

// File: tb/test_mbox_regs.sv
`timescale 1ns/1ps
module test_mbox_regs;
    localparam int DEPTH = 8;
    localparam logic [31:0] MARK = 32'hFFFF_FFFF;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] bus_addr = '0;
    logic        bus_wr_en = 1'b0;
    logic [31:0] bus_wr_data = '0;
    logic        bus_rd_en = 1'b0;
    logic [31:0] bus_rd_data;
    logic        push_valid = 1'b0;
    logic [31:0] push_data = '0;
    logic [31:0] outb_status = 32'h1234_5678;
    logic        irq;

    int checks = 0;
    int fails = 0;
    logic [31:0] model[$];
    bit          m_en = 1'b0;

    always #2.5 clk = ~clk;

    mbox_regs #(.DEPTH(DEPTH), .ADDR_W(12)) i_mbox_regs (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr_en(bus_wr_en),
        .bus_wr_data(bus_wr_data), .bus_rd_en(bus_rd_en), .bus_rd_data(bus_rd_data),
        .push_valid(push_valid), .push_data(push_data), .outb_status(outb_status), .irq(irq)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // One bus cycle with the model stepped alongside; outputs checked 1 ns after the edge.
    task automatic cyc(input bit rd, input bit wr, input logic [11:0] a, input logic [31:0] wd,
                       input bit pv, input logic [31:0] pd, input string tag);
        logic [31:0] exp;
        logic [7:0]  o;
        int          sz;
        bit          pop;
        bit          en_nx;
        @(negedge clk);
        bus_rd_en = rd; bus_wr_en = wr; bus_addr = a; bus_wr_data = wd;
        push_valid = pv; push_data = pd;
        o = a[7:0]; sz = model.size(); pop = 1'b0; exp = '0; en_nx = m_en;
        if (rd) begin
            if (o[7:4] == 4'h8) begin
                exp = (sz > 0) ? model[0] : MARK; pop = (sz > 0);
            end else if (o == 8'h90) exp = (sz > 0) ? model[0] : MARK;
            else if (o == 8'h98) exp = {sz == DEPTH, sz == 0, 22'd0, 8'(sz)};
            else if (o == 8'h9C) exp = {27'd0, sz > 0, 3'd0, m_en};
            else if (o == 8'hB8) exp = outb_status;
            else exp = '0;
        end
        if (wr && o == 8'h9C) en_nx = wd[0];
        if (pop) void'(model.pop_front());
        if (pv && sz < DEPTH) model.push_back(pd);
        m_en = en_nx;
        @(posedge clk);
        #1;
        bus_rd_en = 1'b0; bus_wr_en = 1'b0; push_valid = 1'b0;
        if (rd) check({tag, " R11 rd_data"}, bus_rd_data, exp);
        check({tag, " R7 irq"}, {31'd0, irq}, {31'd0, m_en && model.size() > 0});
    endtask

    task automatic push(input logic [31:0] d, input string tag);
        cyc(0, 0, 12'h0, 0, 1, d, tag);
    endtask
    task automatic rd(input logic [11:0] a, input string tag);
        cyc(1, 0, a, 0, 0, 0, tag);
    endtask
    task automatic wr(input logic [11:0] a, input logic [31:0] d, input string tag);
        cyc(0, 1, a, d, 0, 0, tag);
    endtask

    initial begin
        #(200000 * 5);
        fails++; checks++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R12 reset state
        rd(12'h098, "R12 status after reset");
        rd(12'h09C, "R12 config after reset");
        rd(12'h090, "R12 R4 peek marker after reset");
        rd(12'h080, "R3 empty pop");
        rd(12'h098, "R3 count stays zero");
        // R2 order, R6/R7 enable
        push(32'hA000_0001, "R8 push");
        push(32'hA000_0002, "R8 push");
        push(32'hA000_0003, "R8 push");
        wr(12'h09C, 32'hFFFF_FFFF, "R6 enable write");
        rd(12'h09C, "R6 only bit0 plus pending");
        rd(12'h090, "R4 peek head");
        rd(12'h098, "R4 peek did not remove");
        rd(12'h084, "R2 pop first");
        rd(12'h08C, "R1 R2 pop alias 0x8C");
        rd(12'h098, "R5 status level");
        rd(12'h F80, "R1 upper address bits ignored");
        rd(12'h090, "R9 marker after drain");
        rd(12'h09C, "R6 pending clear");
        // R8 fill to full, drop push on full
        for (int i = 0; i < DEPTH; i++) push(32'hB000_0000 + i, "R8 fill");
        rd(12'h098, "R5 full status");
        push(32'hDEAD_0000, "R8 push on full dropped");
        rd(12'h098, "R8 still full");
        cyc(1, 0, 12'h080, 0, 1, 32'hDEAD_0001, "R8 pop+push on full");
        rd(12'h098, "R8 count after pop+push on full");
        cyc(1, 0, 12'h088, 0, 1, 32'hC000_0001, "R2 pop+push partial");
        // R10 pass-through and unsupported offsets
        outb_status = 32'h8000_0000;
        rd(12'hAB8, "R10 outbound status");
        rd(12'h094, "R10 unsupported read zero");
        rd(12'h0A0, "R10 unsupported read zero");
        wr(12'h098, 32'h0, "R10 write status ignored");
        wr(12'h0A0, 32'h0, "R10 write unsupported ignored");
        wr(12'h080, 32'h0, "R10 write pop offset ignored");
        rd(12'h098, "R10 status unchanged");
        wr(12'h09C, 32'h0000_0010, "R6 write bit4 ignored, disables");
        rd(12'h09C, "R6 config after disable");
        wr(12'h19C, 32'h1, "R1 enable via aliased address");
        // drain
        for (int i = 0; i < DEPTH; i++) rd(12'h080, "R2 drain");
        rd(12'h090, "R9 marker after full drain");
        // random mix against the model
        for (int i = 0; i < 600; i++) begin
            int k;
            logic [11:0] a;
            k = $urandom_range(0, 7);
            case (k)
                0: a = 12'h080; 1: a = 12'h084; 2: a = 12'h090; 3: a = 12'h098;
                4: a = 12'h09C; 5: a = 12'h0B8; 6: a = 12'h0C0; default: a = 12'h380;
            endcase
            cyc($urandom_range(0, 1) == 1, $urandom_range(0, 7) == 0, a, $urandom,
                $urandom_range(0, 2) != 0, $urandom, "R2 R5 R8 random mix");
        end
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule